// File: doc/BRIEF.md
# Tearing-Synchronised Frame Start Trigger

This block sits between a display panel's tearing-effect output and the engine that streams a frame into the panel's memory. It decides the cycle in which a frame transfer may begin, so that writes do not overtake the panel's own scan-out. The panel drives one signal that carries both line and frame markers. The block tells them apart by how long each pulse lasts, and it compares each width against two programmed thresholds.

Software first posts a start request. With tearing sync off (internal mode), the request produces a one-cycle start trigger in the very next cycle. In frame mode the trigger waits for the next vertical marker. In line mode the block counts horizontal markers after a vertical marker and fires when the count reaches a programmed line. Configuration checks raise error flags and hold back tearing triggers while the setup cannot work.

Top module: `tear_sync_trigger`

## Requirements
- R1: After a synchronous reset, start_trig and all four error flags are 0 and no request is pending.
- R2: With trig_mode = 0 (internal), a request sampled at a clock edge gives start_trig = 1 for exactly the following cycle, whatever te_in does.
- R3: A pulse is a run of the synchronised input at a level, and its width is counted in clock cycles. A pulse at the vertical active level with width >= vs_width is a vertical marker. A pulse at the horizontal active level with hs_width <= width < vs_width is a horizontal marker. With trig_mode = 1 (frame), a pending request fires on a vertical marker and not on a horizontal one.
- R4: A pulse shorter than hs_width is ignored. It neither advances the line count nor triggers.
- R5: With trig_mode = 2 (line), a vertical marker clears the line count and each following horizontal marker increments it. The trigger fires when the count becomes equal to trig_line (11 bits). With trig_line = 0 it fires on the vertical marker itself.
- R6: Each request produces at most one start_trig, and no start_trig occurs without a request.
- R7: hs_pol and vs_pol each select their marker's active level: 1 means a high pulse, 0 means a low pulse. A run at the inactive level is never classed as a marker, however long it lasts.
- R8: One cycle after the configuration is applied, err_hs_short shows hs_width < 2 and err_vs_short shows vs_width < 4 in frame mode or vs_width < 2 in line mode. err_width_eq shows hs_width = vs_width, and err_mode shows trig_mode = 3 (reserved). All flags are 0 in internal mode.
- R9: While any error condition holds in a tearing mode, no start_trig is issued and the request stays pending. The request fires on the first valid marker once the configuration is repaired.
- R10: Horizontal markers that arrive before the first vertical marker since reset are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| te_in | input | 1 | Asynchronous tearing-effect input from the panel |
| start_req | input | 1 | One-cycle request to start a frame transfer |
| trig_mode | input | 2 | 0 internal, 1 frame, 2 line, 3 reserved |
| hs_pol | input | 1 | Horizontal marker active level (1 = high) |
| vs_pol | input | 1 | Vertical marker active level (1 = high) |
| hs_width | input | WIDTH_W | Minimum horizontal marker width in cycles |
| vs_width | input | WIDTH_W | Minimum vertical marker width in cycles |
| trig_line | input | LINE_W | Line count at which line mode fires |
| start_trig | output | 1 | One-cycle start trigger |
| err_hs_short | output | 1 | Horizontal width below 2 |
| err_vs_short | output | 1 | Vertical width below the mode minimum |
| err_width_eq | output | 1 | Horizontal and vertical widths equal |
| err_mode | output | 1 | Reserved mode selected |

## Verification
A corrupt width counter or a wrong level register changes how pulses are classed. The port then shows a trigger that comes one marker too early or too late, or never comes. This appears three cycles after the pulse that was misread ends. A line count that is off by one moves the trigger by one horizontal marker. A lost or stuck pending bit shows up at once in internal mode, as a missing trigger in the cycle after the request or as a second trigger nobody asked for. Error flags are registered, so a wrong decode is visible one cycle after the configuration changes.

// File: rtl/tst_pkg.sv
package tst_pkg;
  typedef enum logic [1:0] {
    TM_INTERNAL = 2'd0,
    TM_FRAME    = 2'd1,
    TM_LINE     = 2'd2,
    TM_RSVD     = 2'd3
  } trig_mode_e;
endpackage

// File: rtl/tst_sync.sv
module tst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= '0;
    else     sr <= {sr[STAGES-2:0], d};
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/tst_classifier.sv
module tst_classifier #(
  parameter int WIDTH_W = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               te_s,
  input  logic               hs_pol,
  input  logic               vs_pol,
  input  logic [WIDTH_W-1:0] hs_width,
  input  logic [WIDTH_W-1:0] vs_width,
  output logic               vs_ev,
  output logic               hs_ev
);
  localparam logic [WIDTH_W-1:0] RUN_MAX = '1;
  localparam logic [WIDTH_W-1:0] RUN_ONE = WIDTH_W'(1);

  logic               lvl_q;
  logic [WIDTH_W-1:0] run_q;
  logic               run_end;
  logic               is_vs, is_hs;

  // a run ends when the synchronised level differs from the tracked one
  assign run_end = (te_s != lvl_q);
  assign is_vs = run_end && (lvl_q == vs_pol) && (run_q >= vs_width);
  assign is_hs = run_end && (lvl_q == hs_pol) && (run_q >= hs_width)
                 && (run_q < vs_width);

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q <= 1'b0;
      run_q <= '0;
      vs_ev <= 1'b0;
      hs_ev <= 1'b0;
    end else begin
      vs_ev <= is_vs;
      hs_ev <= is_hs;
      if (run_end) begin
        lvl_q <= te_s;
        run_q <= RUN_ONE;
      end else if (run_q != RUN_MAX) begin
        run_q <= run_q + RUN_ONE;
      end
    end
  end
endmodule

// File: rtl/tst_line_counter.sv
module tst_line_counter #(
  parameter int LINE_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vs_ev,
  input  logic              hs_ev,
  input  logic [LINE_W-1:0] trig_line,
  output logic              line_hit
);
  localparam logic [LINE_W-1:0] LINE_MAX = '1;
  localparam logic [LINE_W-1:0] LINE_ONE = LINE_W'(1);

  logic [LINE_W-1:0] line_q;
  logic              frame_seen_q;
  logic              can_step;

  assign can_step = hs_ev && frame_seen_q && (line_q != LINE_MAX);
  assign line_hit = (vs_ev && (trig_line == '0))
                  || (!vs_ev && can_step && ((line_q + LINE_ONE) == trig_line));

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q       <= '0;
      frame_seen_q <= 1'b0;
    end else if (vs_ev) begin
      line_q       <= '0;
      frame_seen_q <= 1'b1;
    end else if (can_step) begin
      line_q <= line_q + LINE_ONE;
    end
  end
endmodule

// File: rtl/tst_cfg_check.sv
module tst_cfg_check
  import tst_pkg::*;
#(
  parameter int WIDTH_W = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         trig_mode,
  input  logic [WIDTH_W-1:0] hs_width,
  input  logic [WIDTH_W-1:0] vs_width,
  output logic               cfg_ok,
  output logic               err_hs_short,
  output logic               err_vs_short,
  output logic               err_width_eq,
  output logic               err_mode
);
  localparam logic [WIDTH_W-1:0] HS_MIN       = WIDTH_W'(2);
  localparam logic [WIDTH_W-1:0] VS_MIN_LINE  = WIDTH_W'(2);
  localparam logic [WIDTH_W-1:0] VS_MIN_FRAME = WIDTH_W'(4);

  logic               tearing;
  logic [WIDTH_W-1:0] vs_min;
  logic               bad_hs, bad_vs, bad_eq, bad_mode;

  assign tearing  = (trig_mode != TM_INTERNAL);
  assign vs_min   = (trig_mode == TM_LINE) ? VS_MIN_LINE : VS_MIN_FRAME;
  assign bad_hs   = tearing && (hs_width < HS_MIN);
  assign bad_vs   = tearing && (vs_width < vs_min);
  assign bad_eq   = tearing && (hs_width == vs_width);
  assign bad_mode = (trig_mode == TM_RSVD);
  assign cfg_ok   = !(bad_hs || bad_vs || bad_eq || bad_mode);

  always_ff @(posedge clk) begin
    if (rst) begin
      err_hs_short <= 1'b0;
      err_vs_short <= 1'b0;
      err_width_eq <= 1'b0;
      err_mode     <= 1'b0;
    end else begin
      err_hs_short <= bad_hs;
      err_vs_short <= bad_vs;
      err_width_eq <= bad_eq;
      err_mode     <= bad_mode;
    end
  end
endmodule

// File: rtl/tear_sync_trigger.sv
module tear_sync_trigger
  import tst_pkg::*;
#(
  parameter int WIDTH_W     = 6,
  parameter int LINE_W      = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               te_in,
  input  logic               start_req,
  input  logic [1:0]         trig_mode,
  input  logic               hs_pol,
  input  logic               vs_pol,
  input  logic [WIDTH_W-1:0] hs_width,
  input  logic [WIDTH_W-1:0] vs_width,
  input  logic [LINE_W-1:0]  trig_line,
  output logic               start_trig,
  output logic               err_hs_short,
  output logic               err_vs_short,
  output logic               err_width_eq,
  output logic               err_mode
);
  logic te_s;
  logic vs_ev, hs_ev;
  logic line_hit;
  logic cfg_ok;
  logic pending;
  logic pend_now;
  logic fire;

  tst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(te_in), .q(te_s)
  );

  tst_classifier #(.WIDTH_W(WIDTH_W)) u_class (
    .clk(clk), .rst(rst), .te_s(te_s),
    .hs_pol(hs_pol), .vs_pol(vs_pol),
    .hs_width(hs_width), .vs_width(vs_width),
    .vs_ev(vs_ev), .hs_ev(hs_ev)
  );

  tst_line_counter #(.LINE_W(LINE_W)) u_line (
    .clk(clk), .rst(rst), .vs_ev(vs_ev), .hs_ev(hs_ev),
    .trig_line(trig_line), .line_hit(line_hit)
  );

  tst_cfg_check #(.WIDTH_W(WIDTH_W)) u_cfg (
    .clk(clk), .rst(rst), .trig_mode(trig_mode),
    .hs_width(hs_width), .vs_width(vs_width),
    .cfg_ok(cfg_ok),
    .err_hs_short(err_hs_short), .err_vs_short(err_vs_short),
    .err_width_eq(err_width_eq), .err_mode(err_mode)
  );

  assign pend_now = pending || start_req;

  always_comb begin
    unique case (trig_mode)
      TM_INTERNAL: fire = 1'b1;
      TM_FRAME:    fire = vs_ev && cfg_ok;
      TM_LINE:     fire = line_hit && cfg_ok;
      default:     fire = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start_trig <= 1'b0;
      pending    <= 1'b0;
    end else begin
      start_trig <= pend_now && fire;
      pending    <= pend_now && !fire;
    end
  end
endmodule

// File: rtl/tst_checker.sv
module tst_checker #(
  parameter int WIDTH_W = 6
) (
  input logic               clk,
  input logic               rst,
  input logic               start_req,
  input logic [1:0]         trig_mode,
  input logic [WIDTH_W-1:0] hs_width,
  input logic [WIDTH_W-1:0] vs_width,
  input logic               pending,
  input logic               start_trig,
  input logic               err_hs_short,
  input logic               err_vs_short,
  input logic               err_width_eq,
  input logic               err_mode
);
  logic past_ok;
  always_ff @(posedge clk) past_ok <= !rst;

  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> !start_trig && !err_hs_short && !err_mode);

  p_internal_fire_r2: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(start_req && trig_mode == 2'd0) |-> start_trig);

  p_trig_needs_req_r6: assert property (@(posedge clk) disable iff (rst)
    start_trig |-> past_ok && $past(pending || start_req));

  p_err_hs_r8: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(trig_mode != 2'd0 && hs_width < 2) |-> err_hs_short);

  p_err_mode_r8: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(trig_mode == 2'd3) |-> err_mode);

  p_internal_clean_r8: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(trig_mode == 2'd0)
    |-> !err_hs_short && !err_vs_short && !err_width_eq && !err_mode);

  p_bad_cfg_blocks_r9: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(trig_mode != 2'd0 && (hs_width < 2 || hs_width == vs_width))
    |-> !start_trig);
endmodule

bind tear_sync_trigger tst_checker #(.WIDTH_W(WIDTH_W)) i_chk (
  .clk(clk), .rst(rst), .start_req(start_req), .trig_mode(trig_mode),
  .hs_width(hs_width), .vs_width(vs_width), .pending(pending),
  .start_trig(start_trig), .err_hs_short(err_hs_short),
  .err_vs_short(err_vs_short), .err_width_eq(err_width_eq),
  .err_mode(err_mode)
);

// File: tb/test_tear_sync_trigger.sv
`timescale 1ns/1ps
module test_tear_sync_trigger;
  localparam int WIDTH_W = 6;
  localparam int LINE_W  = 11;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic te_in = 1'b0;
  logic start_req = 1'b0;
  logic [1:0] trig_mode = 2'd0;
  logic hs_pol = 1'b1, vs_pol = 1'b1;
  logic [WIDTH_W-1:0] hs_width = 6'd3, vs_width = 6'd8;
  logic [LINE_W-1:0] trig_line = '0;
  logic start_trig, err_hs_short, err_vs_short, err_width_eq, err_mode;

  int total = 0, bad = 0, trig_cnt = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  tear_sync_trigger #(.WIDTH_W(WIDTH_W), .LINE_W(LINE_W)) i_tear_sync_trigger (
    .clk(clk), .rst(rst), .te_in(te_in), .start_req(start_req),
    .trig_mode(trig_mode), .hs_pol(hs_pol), .vs_pol(vs_pol),
    .hs_width(hs_width), .vs_width(vs_width), .trig_line(trig_line),
    .start_trig(start_trig), .err_hs_short(err_hs_short),
    .err_vs_short(err_vs_short), .err_width_eq(err_width_eq),
    .err_mode(err_mode)
  );

  always @(negedge clk) if (!rst && start_trig) trig_cnt++;

  task automatic check(input int act, input int exp, input string req, input string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic request();
    @(negedge clk) start_req = 1'b1;
    @(negedge clk) start_req = 1'b0;
  endtask

  // drive te_in to lvl for n cycles, return to the opposite level, then settle
  task automatic pulse(input logic lvl, input int n);
    @(negedge clk) te_in = lvl;
    repeat (n - 1) @(negedge clk);
    @(negedge clk) te_in = ~lvl;
    idle(8);
  endtask

  task automatic t_reset_r1();
    check(start_trig, 0, "R1", "start_trig after reset");
    check(err_hs_short | err_vs_short | err_width_eq | err_mode, 0, "R1", "error flags after reset");
  endtask

  task automatic t_before_frame_r10();
    int base;
    trig_mode = 2'd2; trig_line = 11'd1; idle(2);
    base = trig_cnt;
    request();
    pulse(1'b1, 5);
    check(trig_cnt - base, 0, "R10", "line marker before first frame marker");
    pulse(1'b1, 10);
    check(trig_cnt - base, 0, "R10", "frame marker with trig_line 1");
    pulse(1'b1, 5);
    check(trig_cnt - base, 1, "R10", "first counted line after frame");
  endtask

  task automatic t_internal_r2();
    int base;
    trig_mode = 2'd0; idle(2);
    base = trig_cnt;
    @(negedge clk) start_req = 1'b1;
    @(negedge clk) begin
      start_req = 1'b0;
      check(start_trig, 1, "R2", "trigger in cycle after request");
    end
    @(negedge clk) check(start_trig, 0, "R2", "trigger lasts one cycle");
    idle(4);
    check(trig_cnt - base, 1, "R6", "one trigger per internal request");
  endtask

  task automatic t_frame_r3();
    int base;
    trig_mode = 2'd1; idle(2);
    base = trig_cnt;
    pulse(1'b1, 10);
    check(trig_cnt - base, 0, "R6", "frame marker without request");
    request();
    pulse(1'b1, 5);
    check(trig_cnt - base, 0, "R3", "line marker in frame mode");
    pulse(1'b1, 2);
    check(trig_cnt - base, 0, "R4", "short pulse in frame mode");
    pulse(1'b1, 10);
    check(trig_cnt - base, 1, "R3", "frame marker fires");
    pulse(1'b1, 10);
    check(trig_cnt - base, 1, "R6", "second frame marker, no new request");
  endtask

  task automatic t_line_r5();
    int base;
    trig_mode = 2'd2; trig_line = 11'd3; idle(2);
    base = trig_cnt;
    request();
    pulse(1'b1, 10);
    pulse(1'b1, 5);
    pulse(1'b1, 2);
    pulse(1'b1, 5);
    check(trig_cnt - base, 0, "R4", "line 2 reached, short pulse not counted");
    pulse(1'b1, 5);
    check(trig_cnt - base, 1, "R5", "trigger at line 3");
    pulse(1'b1, 5);
    check(trig_cnt - base, 1, "R6", "no trigger past the line");
    trig_line = 11'd0;
    request();
    pulse(1'b1, 5);
    check(trig_cnt - base, 1, "R5", "line 0 waits for frame marker");
    pulse(1'b1, 10);
    check(trig_cnt - base, 2, "R5", "line 0 fires on frame marker");
  endtask

  task automatic t_polarity_r7();
    int base;
    trig_mode = 2'd1; idle(2);
    @(negedge clk) te_in = 1'b1;   // idle high while still active-high: low run ignored (no request)
    idle(10);
    vs_pol = 1'b0; hs_pol = 1'b0; idle(2);
    base = trig_cnt;
    request();
    idle(30);
    check(trig_cnt - base, 0, "R7", "long inactive high run");
    pulse(1'b0, 10);
    check(trig_cnt - base, 1, "R7", "active-low frame marker");
    trig_mode = 2'd2; trig_line = 11'd1; idle(2);
    request();
    pulse(1'b0, 10);
    pulse(1'b0, 5);
    check(trig_cnt - base, 2, "R7", "active-low line marker counted");
    @(negedge clk) te_in = 1'b0;
    idle(10);
    vs_pol = 1'b1; hs_pol = 1'b1; idle(4);
  endtask

  task automatic t_errors_r8();
    int base;
    trig_mode = 2'd1; hs_width = 6'd1; vs_width = 6'd8;
    @(negedge clk);
    @(negedge clk) check(err_hs_short, 1, "R8", "hs width 1 flagged");
    hs_width = 6'd3; vs_width = 6'd3;
    @(negedge clk);
    @(negedge clk) begin
      check(err_vs_short, 1, "R8", "vs width 3 in frame mode");
      check(err_width_eq, 1, "R8", "equal widths");
    end
    trig_mode = 2'd2; hs_width = 6'd4;
    @(negedge clk);
    @(negedge clk) check(err_vs_short, 0, "R8", "vs width 3 in line mode");
    trig_mode = 2'd3;
    @(negedge clk);
    @(negedge clk) check(err_mode, 1, "R8", "reserved mode");
    trig_mode = 2'd0; hs_width = 6'd1; vs_width = 6'd1;
    @(negedge clk);
    @(negedge clk) check(err_hs_short | err_vs_short | err_width_eq | err_mode, 0, "R8", "no flags in internal mode");
    trig_mode = 2'd1; hs_width = 6'd1; vs_width = 6'd8; idle(2);
    base = trig_cnt;
    request();
    pulse(1'b1, 10);
    check(trig_cnt - base, 0, "R9", "bad config blocks trigger");
    hs_width = 6'd3; idle(2);
    pulse(1'b1, 10);
    check(trig_cnt - base, 1, "R9", "request kept pending until repaired");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_r1();
    t_before_frame_r10();
    t_internal_r2();
    t_frame_r3();
    t_line_r5();
    t_polarity_r7();
    t_errors_r8();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule